// File: doc/BRIEF.md
# Serial Boot Loader Protocol Controller

This block runs the byte-level conversation between a host and a chip that has just locked onto the host's serial bit rate. The host first sends a sync byte of 0x55, and the block answers with 0xAA. The host then sends a 16-bit program length and that many program bytes. The block returns every length and program byte to the host as it arrives, so the host can verify the link. Program bytes go through a write port into consecutive RAM locations, starting at a fixed load address.

Once the last program byte has arrived, the block asks an external engine whether the nonvolatile store is blank. If the store is not blank, the block asks for a full erase. If everything succeeds, the block sends a final 0xAA and raises a one-cycle strobe that starts execution at the load address. An illegal length or a failed erase instead produces a single 0xFF byte, and the block then freezes for good. The UART sits outside the block, on valid/ready byte streams, and so do the storage engine and the processor.

Top module: `bootld_ctrl`

## Requirements
- R1: After a synchronous reset, rx_ready is 1 and tx_valid, ram_we, blank_req, erase_req and exec_start are all 0.
- R2: While waiting for sync, the block accepts every byte and ignores every byte other than 0x55: nothing is transmitted and nothing is written. The first 0x55 is answered with 0xAA.
- R3: The two bytes that follow sync form the length, high byte first and low byte second.
- R4: Each length byte and each payload byte is echoed on the TX stream exactly once, in arrival order, before the block accepts the next byte.
- R5: Payload byte i (counting from 0) is written with one ram_we pulse at address LOAD_BASE + i. A length of N gives exactly N writes.
- R6: A length of 0, or a length above MAX_LEN (3072 by default), causes both length bytes to be echoed, followed by a single 0xFF. In that case there are no RAM writes, no blank check and no execution, and rx_ready stays 0 from then on.
- R7: blank_req rises only after the last payload byte has been written, and is held until blank_done. blank_done with blank_fail=0 means the store is blank, and no erase is requested.
- R8: blank_done with blank_fail=1 leads to exactly one erase request, held until erase_done.
- R9: erase_done with erase_fail=1 leads to exactly one transmitted 0xFF. After that nothing is transmitted, nothing is executed, and rx_ready stays 0.
- R10: After a blank store or a successful erase, the block transmits 0xAA. Once that byte has been taken, exec_start pulses for exactly one cycle with exec_addr equal to LOAD_BASE.
- R11: A pending TX byte holds tx_data stable until tx_ready accepts it, and rx_ready is 0 while a TX byte is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block accepts the received byte |
| tx_valid | output | 1 | Byte to transmit is pending |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the pending byte |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| blank_req | output | 1 | Blank-check request, held until done |
| blank_done | input | 1 | Blank check finished |
| blank_fail | input | 1 | Store not blank, valid with blank_done |
| erase_req | output | 1 | Erase request, held until done |
| erase_done | input | 1 | Erase finished |
| erase_fail | input | 1 | Erase failed, valid with erase_done |
| exec_start | output | 1 | One-cycle start-execution strobe |
| exec_addr | output | ADDR_W | Entry address (LOAD_BASE) |

## Verification
The hardest paths to reach are the ones that end after the payload: a store that is not blank followed by an erase that fails, and a transfer that fills the load area to exactly MAX_LEN bytes. The bench includes a storage-engine model whose blank and erase answers are set per run. It drives complete sessions, from a sweep of all 255 non-sync bytes through the sync and length to the last payload byte. These sessions cover lengths of 0, 1, 3072, 3073 and 4096, both sides of each storage answer, and a transmitter that stalls every third cycle.

// File: rtl/bootld_pkg.sv
`timescale 1ns/1ps
package bootld_pkg;

    localparam logic [7:0] SYNC_BYTE = 8'h55;
    localparam logic [7:0] ACK_BYTE  = 8'hAA;
    localparam logic [7:0] ERR_BYTE  = 8'hFF;

    typedef enum logic [3:0] {
        ST_SYNC,
        ST_LEN_HI,
        ST_LEN_LO,
        ST_DATA,
        ST_BLANK,
        ST_ERASE,
        ST_ACK,
        ST_GO,
        ST_FAIL,
        ST_HALT,
        ST_RUN
    } boot_state_e;

    // Legal program length: nonzero and within the load area.
    function automatic bit len_ok(input logic [15:0] n, input int unsigned cap);
        return (n != 16'd0) && (32'(n) <= cap);
    endfunction

endpackage

// File: rtl/bootld_txhold.sv
`timescale 1ns/1ps
module bootld_txhold (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= 8'h00;
        end else if (load) begin
            tx_valid <= 1'b1;
            tx_data  <= load_byte;
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    // R11: a pending byte stays put until it is taken
    a_r11_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R11: the sequencer never overwrites a pending byte
    a_r11_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        load |-> !tx_valid);

endmodule

// File: rtl/bootld_loadctr.sv
`timescale 1ns/1ps
module bootld_loadctr #(
    parameter  int unsigned           ADDR_W    = 20,
    parameter  logic [ADDR_W-1:0]     LOAD_BASE = 20'hFF300,
    parameter  int unsigned           MAX_LEN   = 3072,
    localparam int unsigned           CNT_W     = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              len_load,
    input  logic [CNT_W-1:0]  len_value,
    input  logic              step,
    input  logic [7:0]        din,
    output logic              last,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(LOAD_BASE + ADDR_W'(MAX_LEN - 1));

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q  <= '0;
            off_q     <= '0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= 8'h00;
        end else begin
            ram_we <= 1'b0;
            if (len_load) begin
                remain_q <= len_value;
                off_q    <= '0;
            end else if (step) begin
                remain_q  <= remain_q - CNT_W'(1);
                off_q     <= off_q + CNT_W'(1);
                ram_we    <= 1'b1;
                ram_addr  <= LOAD_BASE + {{(ADDR_W-CNT_W){1'b0}}, off_q};
                ram_wdata <= din;
            end
        end
    end

    assign last = (remain_q == CNT_W'(1));

    // R5: no payload byte is taken once the count is used up
    a_r5_no_write_past_end: assert property (@(posedge clk) disable iff (rst)
        step |-> (remain_q != '0));

    // R5: every write lands inside the load area
    a_r5_addr_in_area: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_addr >= LOAD_BASE && ram_addr <= TOP_ADDR));

endmodule

// File: rtl/bootld_seq.sv
`timescale 1ns/1ps
module bootld_seq
    import bootld_pkg::*;
#(
    parameter  int unsigned MAX_LEN = 3072,
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             rx_ready,
    input  logic             tx_pending,
    output logic             tx_load,
    output logic [7:0]       tx_byte,
    output logic             len_load,
    output logic [CNT_W-1:0] len_value,
    output logic             data_step,
    input  logic             last,
    output logic             blank_req,
    input  logic             blank_done,
    input  logic             blank_fail,
    output logic             erase_req,
    input  logic             erase_done,
    input  logic             erase_fail,
    output logic             exec_start
);

    boot_state_e state, state_nx;
    logic [7:0]  len_hi_q;
    logic [15:0] len_full;
    logic        accepting;
    logic        rx_fire;

    assign len_full  = {len_hi_q, rx_data};
    assign len_value = CNT_W'(len_full);
    assign accepting = (state == ST_SYNC) || (state == ST_LEN_HI) ||
                       (state == ST_LEN_LO) || (state == ST_DATA);
    assign rx_ready  = accepting && !tx_pending;
    assign rx_fire   = rx_valid && rx_ready;

    always_comb begin
        state_nx   = state;
        tx_load    = 1'b0;
        tx_byte    = rx_data;
        len_load   = 1'b0;
        data_step  = 1'b0;
        blank_req  = 1'b0;
        erase_req  = 1'b0;
        exec_start = 1'b0;
        unique case (state)
            ST_SYNC: begin
                if (rx_fire && rx_data == SYNC_BYTE) begin
                    tx_load  = 1'b1;
                    tx_byte  = ACK_BYTE;
                    state_nx = ST_LEN_HI;
                end
            end
            ST_LEN_HI: begin
                if (rx_fire) begin
                    tx_load  = 1'b1;
                    state_nx = ST_LEN_LO;
                end
            end
            ST_LEN_LO: begin
                if (rx_fire) begin
                    tx_load = 1'b1;
                    if (len_ok(len_full, MAX_LEN)) begin
                        len_load = 1'b1;
                        state_nx = ST_DATA;
                    end else begin
                        state_nx = ST_FAIL;
                    end
                end
            end
            ST_DATA: begin
                if (rx_fire) begin
                    tx_load   = 1'b1;
                    data_step = 1'b1;
                    if (last) state_nx = ST_BLANK;
                end
            end
            ST_BLANK: begin
                blank_req = 1'b1;
                if (blank_done) state_nx = blank_fail ? ST_ERASE : ST_ACK;
            end
            ST_ERASE: begin
                erase_req = 1'b1;
                if (erase_done) state_nx = erase_fail ? ST_FAIL : ST_ACK;
            end
            ST_ACK: begin
                if (!tx_pending) begin
                    tx_load  = 1'b1;
                    tx_byte  = ACK_BYTE;
                    state_nx = ST_GO;
                end
            end
            ST_GO: begin
                if (!tx_pending) begin
                    exec_start = 1'b1;
                    state_nx   = ST_RUN;
                end
            end
            ST_FAIL: begin
                if (!tx_pending) begin
                    tx_load  = 1'b1;
                    tx_byte  = ERR_BYTE;
                    state_nx = ST_HALT;
                end
            end
            default: state_nx = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_SYNC;
            len_hi_q <= 8'h00;
        end else begin
            state <= state_nx;
            if (state == ST_LEN_HI && rx_fire) len_hi_q <= rx_data;
        end
    end

    // R2: a non-sync byte leaves the block waiting for sync
    a_r2_junk_ignored: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SYNC && rx_fire && rx_data != SYNC_BYTE) |=> (state == ST_SYNC));

    // R9: halt is permanent and refuses input
    a_r9_halt_sticks: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |=> (state == ST_HALT && !rx_ready));

    // R10: the start strobe lasts a single cycle
    a_r10_single_start: assert property (@(posedge clk) disable iff (rst)
        exec_start |=> !exec_start);

endmodule

// File: rtl/bootld_ctrl.sv
`timescale 1ns/1ps
module bootld_ctrl #(
    parameter  int unsigned       ADDR_W    = 20,
    parameter  logic [ADDR_W-1:0] LOAD_BASE = 20'hFF300,
    parameter  int unsigned       MAX_LEN   = 3072
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              blank_req,
    input  logic              blank_done,
    input  logic              blank_fail,
    output logic              erase_req,
    input  logic              erase_done,
    input  logic              erase_fail,
    output logic              exec_start,
    output logic [ADDR_W-1:0] exec_addr
);

    localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

    logic             tx_load;
    logic [7:0]       tx_byte;
    logic             len_load;
    logic [CNT_W-1:0] len_value;
    logic             data_step;
    logic             last;

    bootld_seq #(.MAX_LEN(MAX_LEN)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .tx_pending (tx_valid),
        .tx_load    (tx_load),
        .tx_byte    (tx_byte),
        .len_load   (len_load),
        .len_value  (len_value),
        .data_step  (data_step),
        .last       (last),
        .blank_req  (blank_req),
        .blank_done (blank_done),
        .blank_fail (blank_fail),
        .erase_req  (erase_req),
        .erase_done (erase_done),
        .erase_fail (erase_fail),
        .exec_start (exec_start)
    );

    bootld_txhold u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (tx_load),
        .load_byte (tx_byte),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    bootld_loadctr #(
        .ADDR_W    (ADDR_W),
        .LOAD_BASE (LOAD_BASE),
        .MAX_LEN   (MAX_LEN)
    ) u_load (
        .clk       (clk),
        .rst       (rst),
        .len_load  (len_load),
        .len_value (len_value),
        .step      (data_step),
        .din       (rx_data),
        .last      (last),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    assign exec_addr = LOAD_BASE;

endmodule

// File: tb/bootld_ctrl_test.sv
`timescale 1ns/1ps
module bootld_ctrl_test;

    localparam int          AW   = 20;
    localparam logic [19:0] BASE = 20'hFF300;
    localparam int          MAXL = 3072;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = 8'h00;
    logic          rx_ready;
    logic          tx_valid;
    logic [7:0]    tx_data;
    logic          tx_ready = 1'b1;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [7:0]    ram_wdata;
    logic          blank_req, erase_req;
    logic          blank_done = 1'b0, blank_fail = 1'b0;
    logic          erase_done = 1'b0, erase_fail = 1'b0;
    logic          exec_start;
    logic [AW-1:0] exec_addr;

    bootld_ctrl uut (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .blank_req(blank_req), .blank_done(blank_done), .blank_fail(blank_fail),
        .erase_req(erase_req), .erase_done(erase_done), .erase_fail(erase_fail),
        .exec_start(exec_start), .exec_addr(exec_addr)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    bit blank_bad = 0, erase_bad = 0, stall_en = 0;

    // observation logs, indexed relative to the current run
    logic [7:0]    tx_log [0:4095];
    logic [AW-1:0] wr_addr[0:4095];
    logic [7:0]    wr_data[0:4095];
    int tx_cnt = 0, ram_cnt = 0, blank_cnt = 0, erase_cnt = 0, exec_cnt = 0;
    int tx_base = 0, ram_base = 0, ram_at_blank = 0, overlap = 0;
    logic [AW-1:0] exec_seen = '0;
    logic blank_prev = 1'b0, erase_prev = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_valid && tx_ready) begin
                if (tx_cnt - tx_base < 4096) tx_log[tx_cnt - tx_base] = tx_data;
                tx_cnt++;
            end
            if (ram_we) begin
                if (ram_cnt - ram_base < 4096) begin
                    wr_addr[ram_cnt - ram_base] = ram_addr;
                    wr_data[ram_cnt - ram_base] = ram_wdata;
                end
                ram_cnt++;
            end
            if (blank_req && !blank_prev) begin
                blank_cnt++;
                ram_at_blank = ram_cnt;
            end
            if (erase_req && !erase_prev) erase_cnt++;
            if (exec_start) begin
                exec_cnt++;
                exec_seen = exec_addr;
            end
            if (rx_ready && tx_valid) overlap++;
        end
        blank_prev = blank_req;
        erase_prev = erase_req;
    end

    // storage engine model and transmitter pacing
    initial begin
        int bc;
        int ec;
        int cyc;
        bc = 0; ec = 0; cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            blank_done = 1'b0; blank_fail = 1'b0;
            erase_done = 1'b0; erase_fail = 1'b0;
            tx_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
            if (blank_req) begin
                bc++;
                if (bc == 4) begin blank_done = 1'b1; blank_fail = blank_bad; bc = 0; end
            end else bc = 0;
            if (erase_req) begin
                ec++;
                if (ec == 6) begin erase_done = 1'b1; erase_fail = erase_bad; ec = 0; end
            end else ec = 0;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual run still busy, expected finished");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; rx_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = b;
        do @(negedge clk); while (!rx_ready);
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37 + seed * 11 + (i >> 8)) & 255);
    endfunction

    task automatic run_case(input int len, input bit bb, input bit eb,
                            input bit stall, input bit sweep, input int seed);
        bit ok;
        bit good;
        int expn;
        int bl0, er0, ex0, tx_end, ram_end;
        int bad_echo, bad_wr;
        logic [7:0] hi, lo, fin;
        blank_bad = bb; erase_bad = eb; stall_en = stall;
        do_reset();
        tx_base = tx_cnt; ram_base = ram_cnt;
        bl0 = blank_cnt; er0 = erase_cnt; ex0 = exec_cnt;
        hi = 8'(len >> 8); lo = 8'(len);
        ok   = (len != 0) && (len <= MAXL);
        good = ok && !(bb && eb);
        if (sweep) begin
            for (int v = 0; v < 256; v++) if (v != 8'h55) send(8'(v));
            repeat (3) @(negedge clk);
            chk(tx_cnt == tx_base, "R2", "bytes sent for junk", tx_cnt - tx_base, 0);
            chk(ram_cnt == ram_base, "R2", "writes for junk", ram_cnt - ram_base, 0);
            chk(rx_ready == 1'b1, "R2", "still waiting after junk", rx_ready, 1);
        end
        send(8'h55);
        send(hi);
        send(lo);
        if (ok) for (int i = 0; i < len; i++) send(pat(i, seed));
        expn = 3 + (ok ? len : 0) + 1;
        for (int k = 0; k < 30000 && (tx_cnt - tx_base) < expn; k++) @(negedge clk);
        repeat (12) @(negedge clk);

        chk(tx_cnt - tx_base == expn, "R4", "tx byte count", tx_cnt - tx_base, expn);
        chk(tx_log[0] == 8'hAA, "R2", "sync answer", tx_log[0], 8'hAA);
        chk(tx_log[1] == hi, "R3", "high length echo", tx_log[1], hi);
        chk(tx_log[2] == lo, "R3", "low length echo", tx_log[2], lo);
        bad_echo = 0;
        bad_wr = 0;
        if (ok) begin
            for (int i = 0; i < len; i++) begin
                if (tx_log[3 + i] !== pat(i, seed)) bad_echo++;
                if (wr_addr[i] !== BASE + 20'(i) || wr_data[i] !== pat(i, seed)) bad_wr++;
            end
            chk(bad_echo == 0, stall ? "R11" : "R4", "payload echo mismatches", bad_echo, 0);
            chk(bad_wr == 0, "R5", "RAM write mismatches", bad_wr, 0);
        end
        chk(ram_cnt - ram_base == (ok ? len : 0), ok ? "R5" : "R6", "RAM write count",
            ram_cnt - ram_base, ok ? len : 0);
        fin = good ? 8'hAA : 8'hFF;
        chk(tx_log[expn - 1] == fin, good ? "R10" : (ok ? "R9" : "R6"), "final byte",
            tx_log[expn - 1], fin);
        chk(blank_cnt - bl0 == (ok ? 1 : 0), ok ? "R7" : "R6", "blank checks",
            blank_cnt - bl0, ok ? 1 : 0);
        if (ok) chk(ram_at_blank - ram_base == len, "R7", "writes before blank check",
                    ram_at_blank - ram_base, len);
        chk(erase_cnt - er0 == ((ok && bb) ? 1 : 0), "R8", "erase requests",
            erase_cnt - er0, (ok && bb) ? 1 : 0);
        chk(exec_cnt - ex0 == (good ? 1 : 0), good ? "R10" : "R9", "start strobes",
            exec_cnt - ex0, good ? 1 : 0);
        if (good) chk(exec_seen == BASE, "R10", "entry address", exec_seen, BASE);
        chk(overlap == 0, "R11", "rx_ready while tx pending", overlap, 0);
        chk(rx_ready == 1'b0, good ? "R10" : "R9", "input refused at end", rx_ready, 0);
        if (!good) begin
            tx_end = tx_cnt; ram_end = ram_cnt;
            @(posedge clk); #1;
            rx_valid = 1'b1; rx_data = 8'h55;
            repeat (10) @(negedge clk);
            @(posedge clk); #1;
            rx_valid = 1'b0;
            repeat (3) @(negedge clk);
            chk(tx_cnt == tx_end && ram_cnt == ram_end, ok ? "R9" : "R6",
                "activity after halt", tx_cnt - tx_end + ram_cnt - ram_end, 0);
            chk(rx_ready == 1'b0, ok ? "R9" : "R6", "halt keeps input closed", rx_ready, 0);
        end
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        chk(rx_ready == 1'b1, "R1", "rx_ready after reset", rx_ready, 1);
        chk(tx_valid == 1'b0, "R1", "tx_valid after reset", tx_valid, 0);
        chk(ram_we == 1'b0, "R1", "ram_we after reset", ram_we, 0);
        chk(blank_req == 1'b0 && erase_req == 1'b0, "R1", "requests after reset",
            {blank_req, erase_req}, 0);
        chk(exec_start == 1'b0, "R1", "exec_start after reset", exec_start, 0);

        run_case(5,     0, 0, 0, 1, 1);  // blank store, junk sweep first
        run_case(4,     1, 0, 1, 0, 2);  // erase succeeds, stalled TX
        run_case(3,     1, 1, 0, 0, 3);  // erase fails
        run_case(3,     0, 1, 0, 0, 7);  // blank store, erase answer irrelevant
        run_case(0,     0, 0, 0, 0, 4);  // zero length
        run_case(3073,  0, 0, 0, 0, 5);  // one over the cap
        run_case(4096,  0, 0, 1, 0, 5);  // far over the cap
        run_case(1,     1, 0, 0, 0, 6);  // single byte
        run_case(256,   0, 0, 1, 0, 8);  // byte order 0x01/0x00, stalled TX
        run_case(MAXL,  0, 0, 0, 0, 9);  // full load area

        summary();
        $finish;
    end

endmodule